// File: doc/BRIEF.md
# Shared Packet Buffer Allocator

This block hands out fixed-size frame buffers from a pool that three switch ports draw on. A port asserts its allocate request while it receives a frame. When the block accepts the request, it answers with a grant and the handle (index) of one free buffer. When the frame has been forwarded, the port gives the handle back through a single free channel. Only handles cross the interface. The storage RAM, frame parsing and forwarding logic sit elsewhere.

A configuration bit selects one of two sharing policies at run time. In pooled mode, any port may take any free buffer. In quota mode, each port may hold at most a third of the pool, rounded down. The block keeps a FIFO free list and a held-buffer count for each port. It exposes both so that the rest of the switch can see how the pool is loaded.

Grant, deny and the handle are combinational answers to the request in the same cycle. They are worked out from the state at the start of that cycle. The state itself updates on the clock edge.

Top module: `pkt_buf_alloc`

## Requirements
- R1: After reset, `free_level` is 250, every held count in `port_used` is 0, and the first handle granted is 0.
- R2: Handles leave the free list in FIFO order. The 250 handles start out in the order 0 to 249, and each returned handle joins the tail.
- R3: At most one request is granted per cycle. The grant goes to the lowest-numbered port that is requesting and eligible, and `alloc_idx` carries the handle in that cycle. A grant is never given to a port that is not requesting.
- R4: With `quota_mode` = 0, a requesting port is eligible whenever `free_level` is non-zero, even when it already holds more than 83 buffers.
- R5: With `quota_mode` = 1, a requesting port is eligible only while the pool is non-empty and its held count is below 83 (floor of 250/3).
- R6: A requesting port that is not eligible sees `alloc_deny` for its bit in that cycle, and the deny changes no state. A port that is eligible but loses arbitration sees neither grant nor deny. Grant and deny are never both set for the same port.
- R7: A free with `free_port` in the range 0 to 2 and a non-zero held count for that port returns the handle and lowers that count by one. A free for port 3, or for a port whose held count is zero, is ignored.
- R8: An allocation and a free in the same cycle both take effect. When the pool is empty at the start of the cycle, the allocation is denied and the returned handle becomes available from the next cycle.
- R9: `free_level` plus the sum of all held counts always equals 250.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| quota_mode | input | 1 | 0 = pooled sharing, 1 = one-third quota for each port |
| alloc_req | input | 3 | Allocate request, one bit per port |
| alloc_grant | output | 3 | Grant, one bit per port, at most one set |
| alloc_deny | output | 3 | Deny, one bit per port (pool empty or port at quota) |
| alloc_idx | output | 8 | Buffer handle given with the grant |
| free_valid | input | 1 | Return a handle this cycle |
| free_port | input | 2 | Port returning the handle |
| free_idx | input | 8 | Handle being returned |
| free_level | output | 8 | Number of free buffers |
| port_used | output | 24 | Held count for each port, port p in bits [8p+7:8p] |

## Verification
A wrong read or write pointer in the free list shows up at the next grant as an unexpected `alloc_idx`. This is caught in the very cycle it happens, because the bench model predicts every handle from its own queue. A lost or double-counted buffer breaks the balance between `free_level` and the held counts. It shows on the clock edge after the faulty update, and both the bench and the conservation property flag it. A wrong quota comparison or a wrong arbitration order shows up at once as a grant or deny on the wrong port. The quota fill and the full-pool drain drive the counts to exactly 83 and to an empty pool, so errors at those limits are also caught.

// File: rtl/pba_pkg.sv
package pba_pkg;

    localparam int PBA_NUM_BUFS  = 250;
    localparam int PBA_NUM_PORTS = 3;
    localparam int PBA_IDX_W     = $clog2(PBA_NUM_BUFS);
    localparam int PBA_CNT_W     = $clog2(PBA_NUM_BUFS + 1);
    localparam int PBA_PORT_W    = $clog2(PBA_NUM_PORTS + 1);

    typedef enum logic {
        SHARE_POOLED = 1'b0,
        SHARE_QUOTA  = 1'b1
    } share_mode_e;

    function automatic int quota_of(input int nbufs, input int nports);
        return nbufs / nports;
    endfunction

endpackage

// File: rtl/pba_free_list.sv
module pba_free_list #(
    parameter int NUM_BUFS = 250,
    parameter int IDX_W    = 8,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pop,
    input  logic             push,
    input  logic [IDX_W-1:0] push_idx,
    output logic [IDX_W-1:0] head_idx,
    output logic             empty,
    output logic [CNT_W-1:0] level
);
    localparam logic [CNT_W-1:0] TOTAL = CNT_W'(NUM_BUFS);
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(NUM_BUFS - 1);

    logic [CNT_W-1:0] fresh_ptr;
    logic [CNT_W-1:0] ring_cnt;
    logic [IDX_W-1:0] rd_ptr, wr_ptr;
    logic [IDX_W-1:0] ring [NUM_BUFS];
    logic             fresh_left;
    logic             ring_pop;

    assign fresh_left = (fresh_ptr < TOTAL);
    assign ring_pop   = pop && !fresh_left;
    assign head_idx   = fresh_left ? fresh_ptr[IDX_W-1:0] : ring[rd_ptr];
    assign empty      = !fresh_left && (ring_cnt == '0);
    assign level      = (TOTAL - fresh_ptr) + ring_cnt;

    always_ff @(posedge clk) begin
        if (push) ring[wr_ptr] <= push_idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fresh_ptr <= '0;
            ring_cnt  <= '0;
            rd_ptr    <= '0;
            wr_ptr    <= '0;
        end else begin
            if (pop && fresh_left) fresh_ptr <= fresh_ptr + 1'b1;
            if (ring_pop) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push)     wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            case ({push, ring_pop})
                2'b10:   ring_cnt <= ring_cnt + 1'b1;
                2'b01:   ring_cnt <= ring_cnt - 1'b1;
                default: ring_cnt <= ring_cnt;
            endcase
        end
    end
endmodule

// File: rtl/pba_use_counter.sv
module pba_use_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/pba_arbiter.sv
module pba_arbiter
    import pba_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int CNT_W     = 8,
    parameter int QUOTA     = 83
) (
    input  logic [NUM_PORTS-1:0] req,
    input  logic [CNT_W-1:0]     used [NUM_PORTS],
    input  share_mode_e          mode,
    input  logic                 pool_empty,
    output logic [NUM_PORTS-1:0] grant,
    output logic [NUM_PORTS-1:0] deny,
    output logic                 any_grant
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(QUOTA);

    logic [NUM_PORTS-1:0] eligible;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_elig
        assign eligible[p] = !pool_empty &&
                             ((mode == SHARE_POOLED) || (used[p] < LIMIT));
    end

    assign deny = req & ~eligible;

    always_comb begin
        logic taken;
        taken = 1'b0;
        grant = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (req[p] && eligible[p] && !taken) begin
                grant[p] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

    assign any_grant = |grant;
endmodule

// File: rtl/pkt_buf_alloc.sv
module pkt_buf_alloc
    import pba_pkg::*;
#(
    parameter int NUM_BUFS  = PBA_NUM_BUFS,
    parameter int NUM_PORTS = PBA_NUM_PORTS,
    parameter int IDX_W     = $clog2(NUM_BUFS),
    parameter int CNT_W     = $clog2(NUM_BUFS + 1),
    parameter int PORT_W    = $clog2(NUM_PORTS + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       quota_mode,
    input  logic [NUM_PORTS-1:0]       alloc_req,
    output logic [NUM_PORTS-1:0]       alloc_grant,
    output logic [NUM_PORTS-1:0]       alloc_deny,
    output logic [IDX_W-1:0]           alloc_idx,
    input  logic                       free_valid,
    input  logic [PORT_W-1:0]          free_port,
    input  logic [IDX_W-1:0]           free_idx,
    output logic [CNT_W-1:0]           free_level,
    output logic [NUM_PORTS*CNT_W-1:0] port_used
);
    localparam int QUOTA = quota_of(NUM_BUFS, NUM_PORTS);

    logic [CNT_W-1:0]     used [NUM_PORTS];
    logic [NUM_PORTS-1:0] ret_hit;
    logic                 ret_ok;
    logic                 pool_empty;
    logic                 any_grant;
    share_mode_e          mode;

    assign mode = share_mode_e'(quota_mode);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign ret_hit[p] = free_valid && (free_port == PORT_W'(p)) &&
                            (used[p] != '0);

        pba_use_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .inc   (alloc_grant[p]),
            .dec   (ret_hit[p]),
            .count (used[p])
        );

        assign port_used[p*CNT_W +: CNT_W] = used[p];
    end

    assign ret_ok = |ret_hit;

    pba_arbiter #(
        .NUM_PORTS (NUM_PORTS),
        .CNT_W     (CNT_W),
        .QUOTA     (QUOTA)
    ) u_arb (
        .req        (alloc_req),
        .used       (used),
        .mode       (mode),
        .pool_empty (pool_empty),
        .grant      (alloc_grant),
        .deny       (alloc_deny),
        .any_grant  (any_grant)
    );

    pba_free_list #(
        .NUM_BUFS (NUM_BUFS),
        .IDX_W    (IDX_W),
        .CNT_W    (CNT_W)
    ) u_fl (
        .clk      (clk),
        .rst      (rst),
        .pop      (any_grant),
        .push     (ret_ok),
        .push_idx (free_idx),
        .head_idx (alloc_idx),
        .empty    (pool_empty),
        .level    (free_level)
    );
endmodule

// File: rtl/pba_checker.sv
module pba_checker #(
    parameter int NUM_BUFS  = 250,
    parameter int NUM_PORTS = 3,
    parameter int IDX_W     = 8,
    parameter int CNT_W     = 8,
    parameter int PORT_W    = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       quota_mode,
    input logic [NUM_PORTS-1:0]       alloc_req,
    input logic [NUM_PORTS-1:0]       alloc_grant,
    input logic [NUM_PORTS-1:0]       alloc_deny,
    input logic [IDX_W-1:0]           alloc_idx,
    input logic                       free_valid,
    input logic [PORT_W-1:0]          free_port,
    input logic [IDX_W-1:0]           free_idx,
    input logic [CNT_W-1:0]           free_level,
    input logic [NUM_PORTS*CNT_W-1:0] port_used
);
    localparam int QUOTA = NUM_BUFS / NUM_PORTS;

    int                   held_sum;
    logic [NUM_PORTS-1:0] over_quota_grant;

    always_comb begin
        held_sum         = 0;
        over_quota_grant = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            held_sum += int'(port_used[p*CNT_W +: CNT_W]);
            over_quota_grant[p] = alloc_grant[p] &&
                                  (int'(port_used[p*CNT_W +: CNT_W]) >= QUOTA);
        end
    end

    // R3
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(alloc_grant));

    // R3
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc_grant & ~alloc_req) == '0);

    // R6
    grant_deny_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc_grant & alloc_deny) == '0);

    // R6
    deny_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((|alloc_deny) && !(|alloc_grant) && !free_valid) |=> $stable(free_level));

    // R5
    quota_grant_chk: assert property (@(posedge clk) disable iff (rst)
        quota_mode |-> (over_quota_grant == '0));

    // R4
    pooled_no_deny_chk: assert property (@(posedge clk) disable iff (rst)
        (!quota_mode && free_level != '0) |-> (alloc_deny == '0));

    // R9
    conserve_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(free_level) + held_sum) == NUM_BUFS);
endmodule

bind pkt_buf_alloc pba_checker #(
    .NUM_BUFS  (NUM_BUFS),
    .NUM_PORTS (NUM_PORTS),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W),
    .PORT_W    (PORT_W)
) chk_i (.*);

// File: tb/pkt_buf_alloc_tb_top.sv
module pkt_buf_alloc_tb_top;
    localparam int NB = 250;
    localparam int NP = 3;
    localparam int QT = 83;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        quota_mode = 1'b0;
    logic [2:0]  alloc_req = '0;
    logic [2:0]  alloc_grant, alloc_deny;
    logic [7:0]  alloc_idx;
    logic        free_valid = 1'b0;
    logic [1:0]  free_port = '0;
    logic [7:0]  free_idx = '0;
    logic [7:0]  free_level;
    logic [23:0] port_used;

    int errors = 0;
    int checks = 0;
    string cur_tag = "R1";

    int fq[$];
    int held[3][$];

    always #2 clk = ~clk;

    pkt_buf_alloc dut_i (
        .clk        (clk),
        .rst        (rst),
        .quota_mode (quota_mode),
        .alloc_req  (alloc_req),
        .alloc_grant(alloc_grant),
        .alloc_deny (alloc_deny),
        .alloc_idx  (alloc_idx),
        .free_valid (free_valid),
        .free_port  (free_port),
        .free_idx   (free_idx),
        .free_level (free_level),
        .port_used  (port_used)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s (%s) t=%0t actual=%0d expected=%0d", req, cur_tag, $time, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // One cycle: drive at the falling edge, compare against the model, update the model.
    task automatic step(input logic [2:0] req, input logic mode, input bit fv, input int fp);
        int  fidx = 0;
        bit  fok;
        int  g = -1;
        logic [2:0] eg = '0, ed = '0;
        fok = fv && fp < NP && held[fp].size() > 0;
        if (fok) fidx = held[fp][0];
        alloc_req  = req;
        quota_mode = mode;
        free_valid = fv;
        free_port  = fp[1:0];
        free_idx   = fidx[7:0];
        #1;
        for (int p = 0; p < NP; p++) begin
            bit el;
            el = fq.size() > 0 && (!mode || held[p].size() < QT);
            if (req[p] && !el) ed[p] = 1'b1;
            if (req[p] && el && g < 0) g = p;
        end
        if (g >= 0) eg[g] = 1'b1;
        chk("R3 grant", int'(alloc_grant), int'(eg));
        chk("R6 deny", int'(alloc_deny), int'(ed));
        if (g >= 0) chk("R2 handle", int'(alloc_idx), fq[0]);
        chk("R9 free_level", int'(free_level), fq.size());
        for (int p = 0; p < NP; p++)
            chk("R7 port_used", int'(port_used[p*8 +: 8]), held[p].size());
        if (g >= 0) held[g].push_back(fq.pop_front());
        if (fok) begin
            void'(held[fp].pop_front());
            fq.push_back(fidx);
        end
        @(negedge clk);
    endtask

    initial begin
        #(4 * 20000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NB; i++) fq.push_back(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, first handle is 0
        cur_tag = "R1";
        step(3'b000, 1'b0, 0, 0);
        chk("R1 free_level after reset", int'(free_level), 250);
        step(3'b001, 1'b0, 0, 0);

        // R3: priority among simultaneous requests
        cur_tag = "R3";
        step(3'b111, 1'b0, 0, 0);
        step(3'b110, 1'b0, 0, 0);
        step(3'b100, 1'b0, 0, 0);
        step(3'b101, 1'b0, 0, 0);

        // R5: quota mode, fill port 2 past its limit
        cur_tag = "R5";
        for (int i = 0; i < 90; i++) step(3'b100, 1'b1, 0, 0);
        chk("R5 port2 held at quota", int'(port_used[16 +: 8]), QT);
        cur_tag = "R6";
        step(3'b110, 1'b1, 0, 0);  // port 2 denied, port 1 granted
        step(3'b100, 1'b1, 0, 0);

        // R7: returns, ignored frees
        cur_tag = "R7";
        for (int i = 0; i < 3; i++) step(3'b000, 1'b1, 1, 2);
        step(3'b000, 1'b1, 1, 3);  // out-of-range port
        while (held[0].size() > 0) step(3'b000, 1'b0, 1, 0);
        step(3'b000, 1'b0, 1, 0);  // port 0 holds none: ignored
        chk("R7 port0 empty after ignored free", int'(port_used[0 +: 8]), 0);

        // R4: pooled mode, port 0 drains the whole pool
        cur_tag = "R4";
        for (int i = 0; i < 260; i++) step(3'b001, 1'b0, 0, 0);
        chk("R4 port0 exceeds third of pool", int'(port_used[0 +: 8] > 8'(QT)), 1);
        chk("R4 pool empty", int'(free_level), 0);
        step(3'b011, 1'b0, 0, 0);

        // R8: allocate and free together
        cur_tag = "R8";
        step(3'b010, 1'b0, 1, 0);  // empty: deny, free lands
        step(3'b010, 1'b0, 1, 0);  // both honoured
        step(3'b100, 1'b0, 1, 1);
        step(3'b000, 1'b0, 0, 0);

        // R2: return everything, reuse in return order
        cur_tag = "R2";
        for (int i = 0; i < 60; i++) step(3'b000, 1'b0, 1, i % 3);
        for (int i = 0; i < 30; i++) step(3'b111, 1'b1, 1, 0);
        for (int i = 0; i < 20; i++) step(3'(i), 1'b0, 0, 0);

        finish_run();
    end
endmodule